// File: doc/BRIEF.md
# Run-Time Sized Mesh Shearsort Engine

This block sorts a set of keys held on a two-dimensional grid of registers, using a mesh of neighbour compare-exchange units. A sort is a sequence of rounds. In each round every row is sorted by odd-even transposition, and then every column is sorted the same way. Rows with an even index sort ascending and rows with an odd index sort descending, so the finished grid is ordered along a snake path. The number of rounds is one more than the ceiling of log2 of the active height.

The grid is built for a maximum of `MAX_ROWS` x `MAX_COLS` cells. Each sort uses only the region given at start: a height and a width. A swap flag makes the engine use that region turned on its side, so the given width becomes the active height and the given height becomes the active width. Cells outside the active region keep their contents and never join a compare-exchange.

Keys enter one per handshake on a valid/ready port, in row-major order. They leave one per handshake on a second valid/ready port, in snake order, so the output stream is nondecreasing. The controller has the states IDLE, LOAD, ROWS, COLS, DRAIN and FINISH, with these transitions:
- IDLE to LOAD on `start_i`.
- LOAD to ROWS on the last accepted word.
- ROWS to COLS after a number of steps equal to the active width.
- COLS to ROWS after a number of steps equal to the active height, while rounds remain.
- COLS to DRAIN at the end of the last round.
- DRAIN to FINISH on the last delivered word.
- FINISH to IDLE unconditionally.

Top module: `shear_sort_engine`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `in_ready_o` and `out_valid_o` are all low.
- R2: In IDLE, `start_i` latches the configuration and opens the load port, which accepts exactly H*W words. `in_valid_i` while the engine is idle has no effect, and `start_i` while busy has no effect on the sort.
- R3: With `cfg_swap_i` = 1, the active height H is `cfg_cols_i` and the active width W is `cfg_rows_i`. With `cfg_swap_i` = 0, H is `cfg_rows_i` and W is `cfg_cols_i`.
- R4: `out_valid_o` rises exactly (ceil(log2 H)+1)*(H+W) clock cycles after the clock edge that accepts the last loaded word.
- R5: Words are loaded in row-major order (row 0 first, left to right). The unload order runs left to right on even rows and right to left on odd rows. The unloaded stream is the loaded multiset in nondecreasing order.
- R6: The unload port delivers exactly H*W words. While `out_valid_o` is high and `out_ready_i` is low, `out_key_o` holds its value.
- R7: `done_o` is high for exactly one cycle, the cycle after the last unload handshake, and `busy_o` is low in that cycle.
- R8: Keys left in cells outside the active region, for example from an earlier larger sort, never appear in the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a job (accepted in IDLE only) |
| cfg_rows_i | input | DIM_W | Height of the granted region |
| cfg_cols_i | input | DIM_W | Width of the granted region |
| cfg_swap_i | input | 1 | Use the granted region transposed |
| in_valid_i | input | 1 | Load word valid |
| in_ready_o | output | 1 | Load port open |
| in_key_i | input | KEY_W | Load key |
| out_valid_o | output | 1 | Unload word valid |
| out_ready_i | input | 1 | Unload word taken |
| out_key_o | output | KEY_W | Unload key |
| busy_o | output | 1 | Job in progress (LOAD through DRAIN) |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The assertions rely on the inputs keeping to a few rules. The region presented at `start_i` must be nonzero in both dimensions and must fit the grid once the swap is applied. `out_ready_i` and `in_valid_i` may take any value; the checks on holding the output and on the pulse do not depend on them. The stimulus runs on a square 4x4 grid and uses every height and width from 1 to 4, with and without the swap, so every configuration it applies is legal. It adds back-pressure, load gaps and stray start pulses to exercise the holding and ignoring rules.

// File: rtl/shear_pkg.sv
package shear_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ROWS,
        S_COLS,
        S_DRAIN,
        S_FINISH
    } sort_state_e;

    // smallest r with 2**r >= v (v >= 1)
    function automatic logic [31:0] ceil_log2(input logic [31:0] v);
        logic [31:0] res;
        res = '0;
        for (int i = 0; i < 31; i++) begin
            if ((32'd1 << i) < v) res = 32'(i + 1);
        end
        return res;
    endfunction

endpackage

// File: rtl/shear_cx.sv
module shear_cx #(
    parameter int KEY_W = 8
) (
    input  logic [KEY_W-1:0] a_i,
    input  logic [KEY_W-1:0] b_i,
    input  logic             asc_i,
    output logic [KEY_W-1:0] a_o,
    output logic [KEY_W-1:0] b_o
);
    logic flip;

    assign flip = asc_i ? (a_i > b_i) : (a_i < b_i);
    assign a_o  = flip ? b_i : a_i;
    assign b_o  = flip ? a_i : b_i;
endmodule

// File: rtl/shear_grid.sv
module shear_grid #(
    parameter int MAX_ROWS = 4,
    parameter int MAX_COLS = 4,
    parameter int KEY_W    = 8,
    parameter int DIM_W    = 3
) (
    input  logic             clk,
    input  logic [DIM_W-1:0] act_rows_i,
    input  logic [DIM_W-1:0] act_cols_i,
    input  logic             row_step_i,
    input  logic             col_step_i,
    input  logic             par_i,
    input  logic             wr_en_i,
    input  logic [DIM_W-1:0] wr_row_i,
    input  logic [DIM_W-1:0] wr_col_i,
    input  logic [KEY_W-1:0] wr_key_i,
    input  logic [DIM_W-1:0] rd_row_i,
    input  logic [DIM_W-1:0] rd_col_i,
    output logic [KEY_W-1:0] rd_key_o
);
    logic [KEY_W-1:0] cell_q [MAX_ROWS][MAX_COLS];
    logic [KEY_W-1:0] cell_d [MAX_ROWS][MAX_COLS];
    logic [KEY_W-1:0] h_a    [MAX_ROWS][MAX_COLS];
    logic [KEY_W-1:0] h_b    [MAX_ROWS][MAX_COLS];
    logic [KEY_W-1:0] v_a    [MAX_ROWS][MAX_COLS];
    logic [KEY_W-1:0] v_b    [MAX_ROWS][MAX_COLS];

    for (genvar r = 0; r < MAX_ROWS; r++) begin : g_row
        for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
            if (c + 1 < MAX_COLS) begin : g_h
                shear_cx #(.KEY_W(KEY_W)) u_hcx (
                    .a_i   (cell_q[r][c]),
                    .b_i   (cell_q[r][c+1]),
                    .asc_i ((r % 2) == 0),
                    .a_o   (h_a[r][c]),
                    .b_o   (h_b[r][c])
                );
            end else begin : g_h_edge
                assign h_a[r][c] = '0;
                assign h_b[r][c] = '0;
            end
            if (r + 1 < MAX_ROWS) begin : g_v
                shear_cx #(.KEY_W(KEY_W)) u_vcx (
                    .a_i   (cell_q[r][c]),
                    .b_i   (cell_q[r+1][c]),
                    .asc_i (1'b1),
                    .a_o   (v_a[r][c]),
                    .b_o   (v_b[r][c])
                );
            end else begin : g_v_edge
                assign v_a[r][c] = '0;
                assign v_b[r][c] = '0;
            end
        end
    end

    always_comb begin
        cell_d = cell_q;
        for (int r = 0; r < MAX_ROWS; r++) begin
            for (int c = 0; c < MAX_COLS; c++) begin
                if (wr_en_i && wr_row_i == DIM_W'(r) && wr_col_i == DIM_W'(c))
                    cell_d[r][c] = wr_key_i;
            end
        end
        for (int r = 0; r < MAX_ROWS; r++) begin
            for (int c = 0; c + 1 < MAX_COLS; c++) begin
                if (row_step_i && 1'(c % 2) == par_i &&
                    DIM_W'(r) < act_rows_i && DIM_W'(c + 1) < act_cols_i) begin
                    cell_d[r][c]   = h_a[r][c];
                    cell_d[r][c+1] = h_b[r][c];
                end
            end
        end
        for (int r = 0; r + 1 < MAX_ROWS; r++) begin
            for (int c = 0; c < MAX_COLS; c++) begin
                if (col_step_i && 1'(r % 2) == par_i &&
                    DIM_W'(r + 1) < act_rows_i && DIM_W'(c) < act_cols_i) begin
                    cell_d[r][c]   = v_a[r][c];
                    cell_d[r+1][c] = v_b[r][c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    always_comb begin
        rd_key_o = '0;
        for (int r = 0; r < MAX_ROWS; r++) begin
            for (int c = 0; c < MAX_COLS; c++) begin
                if (rd_row_i == DIM_W'(r) && rd_col_i == DIM_W'(c))
                    rd_key_o = cell_q[r][c];
            end
        end
    end
endmodule

// File: rtl/shear_ctrl.sv
module shear_ctrl
    import shear_pkg::*;
#(
    parameter int DIM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIM_W-1:0] cfg_rows_i,
    input  logic [DIM_W-1:0] cfg_cols_i,
    input  logic             cfg_swap_i,
    input  logic             in_valid_i,
    input  logic             out_ready_i,
    output logic [DIM_W-1:0] act_rows_o,
    output logic [DIM_W-1:0] act_cols_o,
    output logic             row_step_o,
    output logic             col_step_o,
    output logic             par_o,
    output logic             wr_en_o,
    output logic [DIM_W-1:0] idx_row_o,
    output logic [DIM_W-1:0] wr_col_o,
    output logic [DIM_W-1:0] rd_col_o,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic             busy_o,
    output logic             done_o
);
    sort_state_e      state_q, state_d;
    logic [DIM_W-1:0] rows_q, cols_q, nrnd_q, rnd_q, step_q, ir_q, ic_q;
    logic [DIM_W-1:0] eff_rows, eff_cols;
    logic             load_hs, drain_hs, grid_last, row_last, col_last, rnd_last;

    assign eff_rows  = cfg_swap_i ? cfg_cols_i : cfg_rows_i;
    assign eff_cols  = cfg_swap_i ? cfg_rows_i : cfg_cols_i;
    assign load_hs   = (state_q == S_LOAD)  && in_valid_i;
    assign drain_hs  = (state_q == S_DRAIN) && out_ready_i;
    assign grid_last = (ir_q == rows_q - DIM_W'(1)) && (ic_q == cols_q - DIM_W'(1));
    assign row_last  = step_q == cols_q - DIM_W'(1);
    assign col_last  = step_q == rows_q - DIM_W'(1);
    assign rnd_last  = rnd_q == nrnd_q - DIM_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_LOAD;
            S_LOAD:   if (load_hs && grid_last) state_d = S_ROWS;
            S_ROWS:   if (row_last) state_d = S_COLS;
            S_COLS:   if (col_last) state_d = rnd_last ? S_DRAIN : S_ROWS;
            S_DRAIN:  if (drain_hs && grid_last) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // counters and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q <= '0; cols_q <= '0; nrnd_q <= '0;
            rnd_q  <= '0; step_q <= '0; ir_q   <= '0; ic_q <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                rows_q <= eff_rows;
                cols_q <= eff_cols;
                nrnd_q <= DIM_W'(ceil_log2(32'(eff_rows)) + 32'd1);
                rnd_q  <= '0; step_q <= '0; ir_q <= '0; ic_q <= '0;
            end
            if (load_hs || drain_hs) begin
                if (ic_q == cols_q - DIM_W'(1)) begin
                    ic_q <= '0;
                    ir_q <= grid_last ? '0 : ir_q + DIM_W'(1);
                end else begin
                    ic_q <= ic_q + DIM_W'(1);
                end
            end
            if (state_q == S_ROWS) step_q <= row_last ? '0 : step_q + DIM_W'(1);
            if (state_q == S_COLS) begin
                step_q <= col_last ? '0 : step_q + DIM_W'(1);
                if (col_last) rnd_q <= rnd_last ? '0 : rnd_q + DIM_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        in_ready_o  = 1'b0;
        out_valid_o = 1'b0;
        row_step_o  = 1'b0;
        col_step_o  = 1'b0;
        wr_en_o     = 1'b0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            S_IDLE:   busy_o = 1'b0;
            S_LOAD:   begin in_ready_o = 1'b1; wr_en_o = in_valid_i; end
            S_ROWS:   row_step_o = 1'b1;
            S_COLS:   col_step_o = 1'b1;
            S_DRAIN:  out_valid_o = 1'b1;
            S_FINISH: begin busy_o = 1'b0; done_o = 1'b1; end
            default:  busy_o = 1'b0;
        endcase
    end

    assign act_rows_o = rows_q;
    assign act_cols_o = cols_q;
    assign par_o      = step_q[0];
    assign idx_row_o  = ir_q;
    assign wr_col_o   = ic_q;
    assign rd_col_o   = ir_q[0] ? (cols_q - DIM_W'(1) - ic_q) : ic_q;
endmodule

// File: rtl/shear_sort_engine.sv
module shear_sort_engine #(
    parameter int MAX_ROWS = 4,
    parameter int MAX_COLS = 4,
    parameter int KEY_W    = 8,
    localparam int MAX_DIM = (MAX_ROWS > MAX_COLS) ? MAX_ROWS : MAX_COLS,
    localparam int DIM_W   = $clog2(MAX_DIM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIM_W-1:0] cfg_rows_i,
    input  logic [DIM_W-1:0] cfg_cols_i,
    input  logic             cfg_swap_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [KEY_W-1:0] in_key_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [KEY_W-1:0] out_key_o,
    output logic             busy_o,
    output logic             done_o
);
    logic [DIM_W-1:0] act_rows, act_cols, idx_row, wr_col, rd_col;
    logic             row_step, col_step, par, wr_en;

    shear_ctrl #(.DIM_W(DIM_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cfg_rows_i  (cfg_rows_i),
        .cfg_cols_i  (cfg_cols_i),
        .cfg_swap_i  (cfg_swap_i),
        .in_valid_i  (in_valid_i),
        .out_ready_i (out_ready_i),
        .act_rows_o  (act_rows),
        .act_cols_o  (act_cols),
        .row_step_o  (row_step),
        .col_step_o  (col_step),
        .par_o       (par),
        .wr_en_o     (wr_en),
        .idx_row_o   (idx_row),
        .wr_col_o    (wr_col),
        .rd_col_o    (rd_col),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    shear_grid #(
        .MAX_ROWS (MAX_ROWS),
        .MAX_COLS (MAX_COLS),
        .KEY_W    (KEY_W),
        .DIM_W    (DIM_W)
    ) u_grid (
        .clk        (clk),
        .act_rows_i (act_rows),
        .act_cols_i (act_cols),
        .row_step_i (row_step),
        .col_step_i (col_step),
        .par_i      (par),
        .wr_en_i    (wr_en),
        .wr_row_i   (idx_row),
        .wr_col_i   (wr_col),
        .wr_key_i   (in_key_i),
        .rd_row_i   (idx_row),
        .rd_col_i   (rd_col),
        .rd_key_o   (out_key_o)
    );
endmodule

// File: rtl/shear_sort_chk.sv
module shear_sort_chk #(
    parameter int KEY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [KEY_W-1:0] out_key_o,
    input logic             busy_o,
    input logic             done_o
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (busy_o || done_o));

    // R4
    sort_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(!in_ready_o));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_key_o)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(out_valid_o && out_ready_i));
endmodule

bind shear_sort_engine shear_sort_chk #(.KEY_W(KEY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_key_o   (out_key_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/shear_sort_engine_tb_top.sv
module shear_sort_engine_tb_top;
    localparam int MR = 4;
    localparam int MC = 4;
    localparam int KW = 8;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          swap = 1'b0;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [DW-1:0] cfg_rows = '0;
    logic [DW-1:0] cfg_cols = '0;
    logic [KW-1:0] in_key = '0;
    logic          in_ready, out_valid, busy, done;
    logic [KW-1:0] out_key;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int keys [16];
    int expv [16];

    always #4 clk = ~clk;

    shear_sort_engine #(.MAX_ROWS(MR), .MAX_COLS(MC), .KEY_W(KW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cfg_rows_i  (cfg_rows),
        .cfg_cols_i  (cfg_cols),
        .cfg_swap_i  (swap),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .in_key_i    (in_key),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_key_o   (out_key),
        .busy_o      (busy),
        .done_o      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic run_case(input int rows, input int cols, input bit sw, input int pat,
                            input bit poke, input string tag);
        int h, w, n, lg, steps, cyc, j, guard, held, t;
        bit stalled;
        h = sw ? cols : rows;
        w = sw ? rows : cols;
        n = h * w;
        lg = 0;
        while ((1 << lg) < h) lg++;
        steps = (lg + 1) * (h + w);
        for (int i = 0; i < n; i++) begin
            case (pat)
                0: keys[i] = 255 - 7 * i;
                1: keys[i] = 42;
                2: keys[i] = (i * 37 + rows * 11 + cols * 5) % 256;
                default: keys[i] = (i * 5) % 3 + 100;
            endcase
            expv[i] = keys[i];
        end
        for (int a = 1; a < n; a++) begin
            for (int b = a; b > 0 && expv[b-1] > expv[b]; b--) begin
                t = expv[b]; expv[b] = expv[b-1]; expv[b-1] = t;
            end
        end
        @(negedge clk);
        cfg_rows = DW'(rows); cfg_cols = DW'(cols); swap = sw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready && busy, "R2 load port open", int'(in_ready), 1);
        // R5 row-major load
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            if (pat == 2 && (i % 3) == 1) @(negedge clk);
            in_valid = 1'b1;
            in_key = KW'(keys[i]);
            if (!in_ready) check(1'b0, "R2 ready during load", 0, 1);
            @(posedge clk);
            #1;
            in_valid = 1'b0;
        end
        cyc = 0;
        while (!out_valid && cyc < 2000) begin
            start = (poke && cyc == 1);
            @(posedge clk);
            #1;
            cyc++;
        end
        start = 1'b0;
        if (sw) check(cyc == steps, "R3 swapped sort cycles", cyc, steps);
        else    check(cyc == steps, poke ? "R2 start ignored, R4 cycles" : "R4 sort cycles", cyc, steps);
        j = 0; guard = 0; stalled = 1'b0; held = 0;
        while (j < n && guard < 5000) begin
            @(negedge clk);
            if (stalled) check(out_valid && out_key == KW'(held), "R6 key held", int'(out_key), held);
            out_ready = (pat[0]) ? (((j + guard) % 3) != 0) : 1'b1;
            guard++;
            if (!out_valid) begin
                check(1'b0, "R6 valid during unload", 0, 1);
            end else if (out_ready) begin
                check(out_key == KW'(expv[j]), tag, int'(out_key), expv[j]);
                j++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
                held = int'(out_key);
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(done && !busy && !out_valid, "R7 done after last word, R6 count", int'(done), 1);
        @(negedge clk);
        check(!done && !busy, "R7 single pulse", int'(done), 0);
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !done && !in_ready && !out_valid, "R1 during reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !in_ready && !out_valid, "R1 after reset", int'(busy), 0);
        // R2: stray load words while idle
        in_valid = 1'b1;
        in_key = 8'd7;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!in_ready && !busy, "R2 idle ignores in_valid", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        // R5 sweep of every size, both orientations, several patterns
        for (int r = 1; r <= 4; r++) begin
            for (int c = 1; c <= 4; c++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int p = 0; p < 4; p++) begin
                        run_case(r, c, s[0], p, 1'b0, "R5 sorted snake output");
                    end
                end
            end
        end
        // R2 start pulse while busy
        run_case(3, 4, 1'b0, 2, 1'b1, "R2 result after stray start");
        // R3 tall grant used sideways
        run_case(4, 2, 1'b1, 0, 1'b0, "R3 swapped result");
        // R8 leftovers from a full grid must not leak into a small one
        run_case(4, 4, 1'b0, 3, 1'b0, "R8 full grid");
        run_case(2, 2, 1'b0, 0, 1'b0, "R8 small grid isolated");
        run_case(1, 3, 1'b0, 0, 1'b0, "R8 single row isolated");
        finish_run();
    end
endmodule